// File: doc/BRIEF.md
# Timer channel status flag register

This block holds the sticky event flags of one 16-bit counter/timer channel. The counter core around it delivers one-cycle strobes: a match on either compare register, a rollover in either count direction, capture events together with the word count of each capture FIFO, a watchdog reaching zero, and the output flags of this channel and its redundant partner. A raw, unsynchronized secondary input also arrives here. Each strobe that meets its gating conditions sets a flag, and the flag stays set until it is cleared.

A bus write clears flags. Each 1 in the write word clears the flag in that bit position, and each 0 leaves its flag alone. Each capture flag can instead be handed to DMA. While its DMA enable is 1, the flag clears only on a DMA acknowledge, and bus writes to it have no effect. The channel index is a parameter. The watchdog flag exists only on channel 0. The redundancy flag exists only on even channels. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `tmr_status_flags`

## Requirements
- R1: After reset every bit of `flags` is 0.
- R2: `cmp1_hit` sets bit 1 and `cmp2_hit` sets bit 2. Either of them also sets the any-compare flag, bit 3. Each flag is visible on the cycle after the strobe.
- R3: `roll_up` or `roll_down` sets the rollover flag, bit 0.
- R4: A rising transition of `sec_in` sets bit 4 and a falling transition sets bit 5, each exactly once. Each flag appears 3 clock edges after the input changes (two synchronizer stages and the flag register). A transition is counted only while `cnt_en` is 1 at the point of detection.
- R5: Capture flag i (bit 6 for unit 0, bit 7 for unit 1) sets when `cap_evt[i]` is 1, `cnt_en` is 1 and the unit's word count is strictly greater than `watermark`.
- R6: While `cap_dma_en[i]` is 0, capture flag i clears only by a bus write and `dma_ack[i]` is ignored. While `cap_dma_en[i]` is 1, capture flag i clears only on `dma_ack[i]` and bus writes to it are ignored.
- R7: The watchdog flag, bit 8, sets when `wdog_en` and `wdog_zero` are both 1 and `cnt_mode` equals 3'b100 (quadrature decode).
- R8: The redundancy flag, bit 9, sets in any cycle in which `redund_en` is 1 and `oflag_self` differs from `oflag_partner`.
- R9: A cycle with `wr_en` at 1 clears every flag whose `wr_data` bit is 1. Bits of `wr_data` that are 0 have no effect.
- R10: When a set condition and a clear fall in the same cycle, the flag ends up set.
- R11: When `CH_IDX` is not 0, bit 8 always reads 0. When `CH_IDX` is odd, bit 9 always reads 0. This holds whatever the inputs and writes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enabled; gates the edge and capture flags |
| cnt_mode | input | 3 | Counting mode; 3'b100 is quadrature decode |
| cmp1_hit | input | 1 | Match strobe from compare register 1 |
| cmp2_hit | input | 1 | Match strobe from compare register 2 |
| roll_up | input | 1 | Counter wrapped past its maximum while counting up |
| roll_down | input | 1 | Counter wrapped past zero while counting down |
| sec_in | input | 1 | Asynchronous secondary input |
| cap_evt | input | CAP_N | Capture event strobe for each unit |
| cap_cnt | input | CAP_N*CW | Word count of each capture FIFO; unit i occupies bits [i*CW +: CW] |
| watermark | input | CW | Capture FIFO watermark |
| cap_dma_en | input | CAP_N | Hands clearing of each capture flag to DMA |
| dma_ack | input | CAP_N | DMA read acknowledge for each unit |
| wdog_en | input | 1 | Watchdog enabled |
| wdog_zero | input | 1 | Watchdog count reached zero |
| redund_en | input | 1 | Redundancy check enabled |
| oflag_self | input | 1 | This channel's output flag |
| oflag_partner | input | 1 | Partner channel's output flag |
| wr_en | input | 1 | Bus write strobe for the clear operation |
| wr_data | input | 10 | Write-one-to-clear mask |
| flags | output | 10 | Flag register |

## Verification
The bench aims at the boundaries of each gate. It drives a word count equal to the watermark, which must not set the capture flag; a design that compares with greater-or-equal would set it. It runs the watchdog in a mode other than quadrature, which a design missing the mode check would flag. It holds equal output flags while redundancy is enabled, which a design that fails to compare them would flag. Edges on the secondary input while the counter is stopped must leave no flag. The bench also clears right after an edge has been flagged to confirm that one edge sets its flag only once, which catches a level-sensitive detector. A set and a clear in the same cycle must leave the flag set, so a design that gives the clear priority fails. The DMA-owned capture flag must survive a bus write, and the software-owned one must survive a DMA acknowledge; a design that mixes up the clear paths fails either check. A second, odd-numbered instance must keep the watchdog and redundancy bits at 0 while both are provoked.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int FLAG_W  = 10;
  localparam int B_ROLL  = 0;
  localparam int B_CMP1  = 1;
  localparam int B_CMP2  = 2;
  localparam int B_CMPA  = 3;
  localparam int B_RISE  = 4;
  localparam int B_FALL  = 5;
  localparam int B_CAP0  = 6;
  localparam int B_WDOG  = 8;
  localparam int B_RDNT  = 9;
  localparam logic [2:0] MODE_QUAD = 3'b100;
endpackage

// File: rtl/tsf_sticky.sv
module tsf_sticky #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (IMPL) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i | (q & ~clr_i);
      end
      assign flag_o = q;

      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
    end else begin : g_none
      assign flag_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tsf_edge_det.sv
module tsf_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  input  logic enable,
  output logic rise_o,
  output logic fall_o
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sig_async;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign rise_o = enable & s2 & ~s3;
  assign fall_o = enable & ~s2 & s3;

  assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  assert_single_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tsf_cap_flag.sv
module tsf_cap_flag #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          cnt_en,
  input  logic [CW-1:0] word_cnt,
  input  logic [CW-1:0] wm,
  input  logic          dma_en,
  input  logic          dma_ack,
  input  logic          wr_clr,
  output logic          flag_o
);
  logic set_c, clr_c;
  assign set_c = evt & cnt_en & (word_cnt > wm);
  assign clr_c = dma_en ? dma_ack : wr_clr;

  tsf_sticky #(.IMPL(1'b1)) u_bit (
    .clk(clk), .rst_n(rst_n), .set_i(set_c), .clr_i(clr_c), .flag_o(flag_o)
  );

  assert_dma_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !dma_ack && !set_c) |=> $stable(flag_o));
  assert_sw_ignores_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !wr_clr && !set_c) |=> $stable(flag_o));
  assert_no_set_at_wm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt <= wm) |=> !$rose(flag_o));
endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
  import tsf_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int CAP_N  = 2,
  parameter int CW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic [2:0]          cnt_mode,
  input  logic                cmp1_hit,
  input  logic                cmp2_hit,
  input  logic                roll_up,
  input  logic                roll_down,
  input  logic                sec_in,
  input  logic [CAP_N-1:0]    cap_evt,
  input  logic [CAP_N*CW-1:0] cap_cnt,
  input  logic [CW-1:0]       watermark,
  input  logic [CAP_N-1:0]    cap_dma_en,
  input  logic [CAP_N-1:0]    dma_ack,
  input  logic                wdog_en,
  input  logic                wdog_zero,
  input  logic                redund_en,
  input  logic                oflag_self,
  input  logic                oflag_partner,
  input  logic                wr_en,
  input  logic [FLAG_W-1:0]   wr_data,
  output logic [FLAG_W-1:0]   flags
);
  localparam bit HAS_WDOG = (CH_IDX == 0);
  localparam bit HAS_RDNT = ((CH_IDX % 2) == 0);

  logic [FLAG_W-1:0] clr_v;
  logic rise_s, fall_s;
  assign clr_v = wr_en ? wr_data : '0;

  tsf_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig_async(sec_in), .enable(cnt_en),
    .rise_o(rise_s), .fall_o(fall_s)
  );

  tsf_sticky u_roll (.clk(clk), .rst_n(rst_n), .set_i(roll_up | roll_down),
    .clr_i(clr_v[B_ROLL]), .flag_o(flags[B_ROLL]));
  tsf_sticky u_cmp1 (.clk(clk), .rst_n(rst_n), .set_i(cmp1_hit),
    .clr_i(clr_v[B_CMP1]), .flag_o(flags[B_CMP1]));
  tsf_sticky u_cmp2 (.clk(clk), .rst_n(rst_n), .set_i(cmp2_hit),
    .clr_i(clr_v[B_CMP2]), .flag_o(flags[B_CMP2]));
  tsf_sticky u_cmpa (.clk(clk), .rst_n(rst_n), .set_i(cmp1_hit | cmp2_hit),
    .clr_i(clr_v[B_CMPA]), .flag_o(flags[B_CMPA]));
  tsf_sticky u_rise (.clk(clk), .rst_n(rst_n), .set_i(rise_s),
    .clr_i(clr_v[B_RISE]), .flag_o(flags[B_RISE]));
  tsf_sticky u_fall (.clk(clk), .rst_n(rst_n), .set_i(fall_s),
    .clr_i(clr_v[B_FALL]), .flag_o(flags[B_FALL]));

  genvar gi;
  generate
    for (gi = 0; gi < CAP_N; gi++) begin : g_cap
      tsf_cap_flag #(.CW(CW)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt(cap_evt[gi]), .cnt_en(cnt_en),
        .word_cnt(cap_cnt[gi*CW +: CW]), .wm(watermark),
        .dma_en(cap_dma_en[gi]), .dma_ack(dma_ack[gi]),
        .wr_clr(clr_v[B_CAP0+gi]), .flag_o(flags[B_CAP0+gi])
      );
    end
  endgenerate

  tsf_sticky #(.IMPL(HAS_WDOG)) u_wdog (.clk(clk), .rst_n(rst_n),
    .set_i(wdog_en & wdog_zero & (cnt_mode == MODE_QUAD)),
    .clr_i(clr_v[B_WDOG]), .flag_o(flags[B_WDOG]));
  tsf_sticky #(.IMPL(HAS_RDNT)) u_rdnt (.clk(clk), .rst_n(rst_n),
    .set_i(redund_en & (oflag_self ^ oflag_partner)),
    .clr_i(clr_v[B_RDNT]), .flag_o(flags[B_RDNT]));

  assert_any_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp1_hit || cmp2_hit) |=> flags[B_CMPA]);
  assert_roll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_up || roll_down) |=> flags[B_ROLL]);

  generate
    if (HAS_WDOG) begin : g_wd_chk
      assert_wdog_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode != MODE_QUAD) |=> !$rose(flags[B_WDOG]));
    end else begin : g_wd_off
      assert_wdog_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[B_WDOG]);
    end
    if (HAS_RDNT) begin : g_rd_chk
      assert_rdnt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!redund_en || (oflag_self == oflag_partner)) |=> !$rose(flags[B_RDNT]));
    end else begin : g_rd_off
      assert_rdnt_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[B_RDNT]);
    end
  endgenerate
endmodule

// File: tb/tmr_status_flags_test.sv
module tmr_status_flags_test;
  localparam int CAP_N = 2;
  localparam int CW    = 4;
  localparam int FW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic [2:0] cnt_mode = 3'b000;
  logic cmp1_hit = 0, cmp2_hit = 0, roll_up = 0, roll_down = 0, sec_in = 0;
  logic [CAP_N-1:0] cap_evt = '0, cap_dma_en = '0, dma_ack = '0;
  logic [CAP_N*CW-1:0] cap_cnt = '0;
  logic [CW-1:0] watermark = '0;
  logic wdog_en = 0, wdog_zero = 0, redund_en = 0, oflag_self = 0, oflag_partner = 0;
  logic wr_en = 0;
  logic [FW-1:0] wr_data = '0;
  logic [FW-1:0] flags, flags_odd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_status_flags #(.CH_IDX(0), .CAP_N(CAP_N), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_mode(cnt_mode),
    .cmp1_hit(cmp1_hit), .cmp2_hit(cmp2_hit), .roll_up(roll_up), .roll_down(roll_down),
    .sec_in(sec_in), .cap_evt(cap_evt), .cap_cnt(cap_cnt), .watermark(watermark),
    .cap_dma_en(cap_dma_en), .dma_ack(dma_ack), .wdog_en(wdog_en), .wdog_zero(wdog_zero),
    .redund_en(redund_en), .oflag_self(oflag_self), .oflag_partner(oflag_partner),
    .wr_en(wr_en), .wr_data(wr_data), .flags(flags));

  tmr_status_flags #(.CH_IDX(3), .CAP_N(CAP_N), .CW(CW)) uut_odd (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_mode(cnt_mode),
    .cmp1_hit(cmp1_hit), .cmp2_hit(cmp2_hit), .roll_up(roll_up), .roll_down(roll_down),
    .sec_in(sec_in), .cap_evt(cap_evt), .cap_cnt(cap_cnt), .watermark(watermark),
    .cap_dma_en(cap_dma_en), .dma_ack(dma_ack), .wdog_en(wdog_en), .wdog_zero(wdog_zero),
    .redund_en(redund_en), .oflag_self(oflag_self), .oflag_partner(oflag_partner),
    .wr_en(wr_en), .wr_data(wr_data), .flags(flags_odd));

  // stimulus {cmp1,cmp2,roll_up,roll_down, wdog_en,wdog_zero, mode[2:0], redund_en,self,partner}, expected flags
  localparam logic [21:0] VEC [12] = '{
    {12'b1000_00_000_000, 10'h00A},
    {12'b0100_00_000_000, 10'h00C},
    {12'b1100_00_000_000, 10'h00E},
    {12'b0010_00_000_000, 10'h001},
    {12'b0001_00_000_000, 10'h001},
    {12'b0000_11_100_000, 10'h100},
    {12'b0000_11_011_000, 10'h000},
    {12'b0000_01_100_000, 10'h000},
    {12'b0000_00_000_110, 10'h200},
    {12'b0000_00_000_111, 10'h000},
    {12'b0000_00_000_010, 10'h000},
    {12'b0000_00_000_000, 10'h000}
  };

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = '1;
    tick(1);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(2);
    chk("R1 reset", flags, '0);
    rst_n = 1;
    tick(2);
    chk("R1 after release", flags, '0);

    // table walk: R2 R3 R7 R8, odd instance R11
    for (int i = 0; i < 12; i++) begin
      {cmp1_hit, cmp2_hit, roll_up, roll_down, wdog_en, wdog_zero, cnt_mode,
       redund_en, oflag_self, oflag_partner} = VEC[i][21:10];
      tick(1);
      {cmp1_hit, cmp2_hit, roll_up, roll_down, wdog_en, wdog_zero, cnt_mode,
       redund_en, oflag_self, oflag_partner} = '0;
      tick(1);
      chk($sformatf("R2/R3/R7/R8 vec %0d", i), flags, VEC[i][9:0]);
      chk($sformatf("R11 odd vec %0d", i), flags_odd, VEC[i][9:0] & 10'h0FF);
      clear_all();
      chk($sformatf("R9 clear vec %0d", i), flags, '0);
    end

    // R4 edges
    cnt_en = 1;
    sec_in = 1;
    tick(2);
    chk("R4 rise not before third edge", flags, '0);
    tick(1);
    chk("R4 rise flag", flags, 10'h010);
    clear_all();
    tick(3);
    chk("R4 rise counted once", flags, '0);
    sec_in = 0;
    tick(4);
    chk("R4 fall flag", flags, 10'h020);
    clear_all();
    cnt_en = 0;
    sec_in = 1; tick(4);
    sec_in = 0; tick(4);
    chk("R4 edges ignored when stopped", flags, '0);

    // R5 capture threshold
    cnt_en = 1;
    watermark = 4'd2;
    cap_cnt = {4'd0, 4'd2};
    cap_evt = 2'b01; tick(1); cap_evt = '0; tick(1);
    chk("R5 count equal to watermark", flags, '0);
    cap_cnt = {4'd3, 4'd3};
    cap_evt = 2'b11; tick(1); cap_evt = '0; tick(1);
    chk("R5 count above watermark", flags, 10'h0C0);
    clear_all();
    cnt_en = 0;
    cap_evt = 2'b11; tick(1); cap_evt = '0; tick(1);
    chk("R5 counter stopped", flags, '0);
    cnt_en = 1;

    // R9 selective clear
    cap_evt = 2'b01; roll_up = 1; tick(1); cap_evt = '0; roll_up = 0; tick(1);
    chk("R9 setup", flags, 10'h041);
    wr_en = 1; wr_data = 10'h000; tick(1); wr_en = 0;
    chk("R9 write zero", flags, 10'h041);
    wr_en = 1; wr_data = 10'h001; tick(1); wr_en = 0; wr_data = '0;
    chk("R9 write one clears bit 0 only", flags, 10'h040);

    // R6 software mode ignores ack
    dma_ack = 2'b01; tick(1); dma_ack = '0;
    chk("R6 ack ignored in software mode", flags, 10'h040);
    // R6 DMA mode ignores writes, clears on ack
    cap_dma_en = 2'b01;
    wr_en = 1; wr_data = 10'h040; tick(1); wr_en = 0; wr_data = '0;
    chk("R6 write ignored in DMA mode", flags, 10'h040);
    dma_ack = 2'b01; tick(1); dma_ack = '0;
    chk("R6 ack clears in DMA mode", flags, '0);
    cap_dma_en = '0;

    // R10 set beats clear
    cmp1_hit = 1; wr_en = 1; wr_data = '1; tick(1);
    cmp1_hit = 0; wr_en = 0; wr_data = '0;
    chk("R10 set wins", flags, 10'h00A);
    clear_all();

    // R11 writes on absent bits of odd channel
    wdog_en = 1; wdog_zero = 1; cnt_mode = 3'b100; redund_en = 1; oflag_self = 1;
    tick(2);
    chk("R11 odd absent bits", flags_odd & 10'h300, '0);
    chk("R7/R8 even channel both set", flags & 10'h300, 10'h300);

    finish_run();
  end
endmodule